// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block is a single DMA channel that follows a linked list of descriptors held in host memory. Software loads a 64-bit head pointer into two register words. It then writes the control/status word with the enable, start and list-mode bits all set. From then on the channel runs without further help. It reads each 32-byte descriptor one word at a time over a request/acknowledge memory port. It passes the host address, byte count and direction of that descriptor to a request/done transfer port, and waits for the transfer to finish. It then moves on to the address held in the descriptor's link words.

The flags that steer the walk sit in the low bits of the link-low word, below the 32-byte alignment boundary: end of list, interrupt on completion, and direction. A list whose last link points back at its own head keeps cycling until it meets an end flag or software requests a stop. A stop takes effect only between descriptors. Software watches progress through a done bit, a sticky interrupt bit that it clears by writing a one, and a running byte total. A one-cycle interrupt pulse accompanies every setting of the sticky bit.

Top module: `sgdma_walker`

## Requirements
- R1: A write to offset 0x20 with bits 0, 1 and 8 all set, while done is 1, starts a walk. It clears done and the byte total, and the first fetch goes to {word@0x14, word@0x10 & 0xFFFFFFE0}. A write that lacks any of those three bits starts nothing.
- R2: A descriptor is fetched as eight single-word reads at base+0, +4, …, +28, in rising order. Each read holds mem_req and mem_addr steady until mem_ack. Word 0 is host address low, 1 host address high, 4 byte count, 6 link low, 7 link high; words 2, 3 and 5 are not used.
- R3: After the eighth word, xfer_req rises with xfer_addr = {word1, word0}, xfer_len = word4 and xfer_to_host = bit 3 of word6. These are held unchanged until xfer_done.
- R4: When a transfer completes and the walk does not end, the next fetch starts at {word7, word6 & 0xFFFFFFE0}. A link back to an earlier descriptor therefore repeats the walk with no limit.
- R5: If bit 1 of word6 is set, done (offset 0x20 bit 4) becomes 1 in the cycle after that descriptor's transfer completes. No memory or transfer request follows.
- R6: The byte total at offset 0x24 changes only on a start, which clears it, or on a transfer completion, which adds that descriptor's byte count.
- R7: If bit 2 of word6 is set, completion of that transfer sets offset 0x20 bit 5. The irq output is high for exactly that one cycle.
- R8: Writing a 1 to offset 0x20 bit 5 clears the sticky interrupt bit.
- R9: Writing offset 0x20 bit 2 while done is 0 lets the current descriptor finish its transfer, then sets done with no further fetch.
- R10: While done is 1, an abort write has no effect. While done is 0, a start write has no effect and the walk continues on its list.
- R11: After reset, offset 0x20 reads 0x10 (done only), offset 0x24 reads 0, and mem_req, xfer_req and irq are low.
- R12: Offsets 0x10 and 0x14 read back the last value written, with no masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 64 | Byte address of the requested word |
| mem_ack | input | 1 | Read accepted, mem_rdata valid |
| mem_rdata | input | 32 | Descriptor word |
| xfer_req | output | 1 | Transfer request, held until xfer_done |
| xfer_addr | output | 64 | Host byte address of the transfer |
| xfer_len | output | 32 | Transfer length in bytes |
| xfer_to_host | output | 1 | 1 = write toward host, 0 = read from host |
| xfer_done | input | 1 | Transfer finished |
| irq | output | 1 | One-cycle pulse when the sticky interrupt bit is set |

## Verification
A wrong word index or base pointer in the walker appears on mem_addr at the next fetch cycle. A misplaced field capture appears on xfer_addr, xfer_len or xfer_to_host in the first cycle xfer_req is high. The bench model predicts every fetch address and every transfer from its own copy of memory, so a bad link mask or a missed loop-back is caught within one descriptor. A byte total that drifts, or an end or stop decision that comes late, shows on the 0x24 read value or as a request while the model is idle, both in the cycle after the completion that caused it.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;

  localparam int DESC_WORDS = 8;
  localparam int WIDX_W     = $clog2(DESC_WORDS);

  // word slots inside a descriptor (fetch order is the slot order)
  localparam int SLOT_HADDR_LO = 0;
  localparam int SLOT_HADDR_HI = 1;
  localparam int SLOT_COUNT    = 4;
  localparam int SLOT_LINK_LO  = 6;
  localparam int SLOT_LINK_HI  = 7;

  // flag bits in the link-low word
  localparam int FLG_LAST = 1;
  localparam int FLG_IRQ  = 2;
  localparam int FLG_DIR  = 3;
  localparam logic [31:0] LINK_MASK = 32'hFFFF_FFE0;

  // register offsets
  localparam int OFF_PTR_LO = 'h10;
  localparam int OFF_PTR_HI = 'h14;
  localparam int OFF_CSR    = 'h20;
  localparam int OFF_TOTAL  = 'h24;

  // control/status bits
  localparam int CB_EN    = 0;
  localparam int CB_GO    = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_DONE  = 4;
  localparam int CB_IRQ   = 5;
  localparam int CB_LIST  = 8;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_MOVE  = 2'd2
  } walk_state_t;

  function automatic logic [63:0] link_target(input logic [31:0] lo, input logic [31:0] hi);
    return {hi, lo & LINK_MASK};
  endfunction

  function automatic logic [63:0] slot_addr(input logic [63:0] base, input logic [WIDX_W-1:0] idx);
    return base + 64'({idx, 2'b00});
  endfunction

  function automatic logic is_launch(input logic [31:0] w);
    return w[CB_EN] & w[CB_GO] & w[CB_LIST];
  endfunction

endpackage

// File: rtl/sgdma_regs.sv
`timescale 1ns/1ps
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int REG_AW  = 6,
  parameter int BYTES_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              seg_fin,
  input  logic [31:0]       seg_len,
  input  logic              seg_irq,
  input  logic              walk_end,
  output logic              launch,
  output logic              stop_req,
  output logic              chan_done,
  output logic [63:0]       head_ptr,
  output logic              irq
);

  logic [31:0]        ptr_lo_q, ptr_hi_q;
  logic               done_q, sts_q, stop_pend_q, irq_q;
  logic [BYTES_W-1:0] total_q;
  logic               csr_wr, stop_hit;

  function automatic logic [BYTES_W-1:0] add_len(input logic [BYTES_W-1:0] acc, input logic [31:0] len);
    return acc + BYTES_W'(len);
  endfunction

  assign csr_wr    = reg_we && (reg_addr == REG_AW'(OFF_CSR));
  assign launch    = csr_wr && is_launch(reg_wdata) && done_q;
  assign stop_hit  = csr_wr && reg_wdata[CB_STOP] && !done_q;
  assign stop_req  = stop_pend_q || stop_hit;
  assign chan_done = done_q;
  assign head_ptr  = link_target(ptr_lo_q, ptr_hi_q);
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_lo_q    <= '0;
      ptr_hi_q    <= '0;
      done_q      <= 1'b1;
      sts_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      irq_q       <= 1'b0;
      total_q     <= '0;
    end else begin
      if (reg_we && reg_addr == REG_AW'(OFF_PTR_LO)) ptr_lo_q <= reg_wdata;
      if (reg_we && reg_addr == REG_AW'(OFF_PTR_HI)) ptr_hi_q <= reg_wdata;

      if (launch)        done_q <= 1'b0;
      else if (walk_end) done_q <= 1'b1;

      if (walk_end || launch) stop_pend_q <= 1'b0;
      else if (stop_hit)      stop_pend_q <= 1'b1;

      if (seg_irq)                        sts_q <= 1'b1;
      else if (csr_wr && reg_wdata[CB_IRQ]) sts_q <= 1'b0;
      irq_q <= seg_irq;

      if (launch)       total_q <= '0;
      else if (seg_fin) total_q <= add_len(total_q, seg_len);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(OFF_PTR_LO)) reg_rdata = ptr_lo_q;
    if (reg_addr == REG_AW'(OFF_PTR_HI)) reg_rdata = ptr_hi_q;
    if (reg_addr == REG_AW'(OFF_CSR)) begin
      reg_rdata[CB_DONE] = done_q;
      reg_rdata[CB_IRQ]  = sts_q;
    end
    if (reg_addr == REG_AW'(OFF_TOTAL)) reg_rdata = 32'(total_q);
  end

  // R6
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !seg_fin) |=> $stable(total_q));
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> sts_q);

endmodule

// File: rtl/sgdma_walk.sv
`timescale 1ns/1ps
module sgdma_walk
  import sgdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic [63:0] head_ptr,
  input  logic        stop_req,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        xfer_req,
  output logic [63:0] xfer_addr,
  output logic [31:0] xfer_len,
  output logic        xfer_to_host,
  input  logic        xfer_done,
  output logic        seg_fin,
  output logic [31:0] seg_len,
  output logic        seg_irq,
  output logic        walk_end
);

  localparam logic [WIDX_W-1:0] LAST_SLOT = WIDX_W'(DESC_WORDS - 1);

  walk_state_t       state_q;
  logic [63:0]       cur_q;
  logic [WIDX_W-1:0] widx_q;
  logic [31:0]       ha_lo_q, ha_hi_q, cnt_q, lk_lo_q, lk_hi_q;

  assign mem_req      = (state_q == WK_FETCH);
  assign mem_addr     = slot_addr(cur_q, widx_q);
  assign xfer_req     = (state_q == WK_MOVE);
  assign xfer_addr    = {ha_hi_q, ha_lo_q};
  assign xfer_len     = cnt_q;
  assign xfer_to_host = lk_lo_q[FLG_DIR];

  assign seg_fin  = xfer_req && xfer_done;
  assign seg_len  = cnt_q;
  assign seg_irq  = seg_fin && lk_lo_q[FLG_IRQ];
  assign walk_end = seg_fin && (lk_lo_q[FLG_LAST] || stop_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      cur_q   <= '0;
      widx_q  <= '0;
      ha_lo_q <= '0;
      ha_hi_q <= '0;
      cnt_q   <= '0;
      lk_lo_q <= '0;
      lk_hi_q <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (launch) begin
          cur_q   <= head_ptr;
          widx_q  <= '0;
          state_q <= WK_FETCH;
        end
        WK_FETCH: if (mem_ack) begin
          unique case (int'(widx_q))
            SLOT_HADDR_LO: ha_lo_q <= mem_rdata;
            SLOT_HADDR_HI: ha_hi_q <= mem_rdata;
            SLOT_COUNT:    cnt_q   <= mem_rdata;
            SLOT_LINK_LO:  lk_lo_q <= mem_rdata;
            SLOT_LINK_HI:  lk_hi_q <= mem_rdata;
            default: ;
          endcase
          widx_q <= widx_q + 1'b1;
          if (widx_q == LAST_SLOT) state_q <= WK_MOVE;
        end
        WK_MOVE: if (xfer_done) begin
          if (walk_end) begin
            state_q <= WK_IDLE;
          end else begin
            cur_q   <= link_target(lk_lo_q, lk_hi_q);
            widx_q  <= '0;
            state_q <= WK_FETCH;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  // R2
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R3
  move_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)
                                   && $stable(xfer_to_host)));
  // R2
  fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (mem_addr[4:0] == 5'd0));

endmodule

// File: rtl/sgdma_walker.sv
`timescale 1ns/1ps
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int REG_AW  = 6,
  parameter int BYTES_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [63:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              xfer_req,
  output logic [63:0]       xfer_addr,
  output logic [31:0]       xfer_len,
  output logic              xfer_to_host,
  input  logic              xfer_done,
  output logic              irq
);

  logic        launch, stop_req, chan_done;
  logic [63:0] head_ptr;
  logic        seg_fin, seg_irq, walk_end;
  logic [31:0] seg_len;

  sgdma_regs #(.REG_AW(REG_AW), .BYTES_W(BYTES_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .seg_fin   (seg_fin),
    .seg_len   (seg_len),
    .seg_irq   (seg_irq),
    .walk_end  (walk_end),
    .launch    (launch),
    .stop_req  (stop_req),
    .chan_done (chan_done),
    .head_ptr  (head_ptr),
    .irq       (irq)
  );

  sgdma_walk u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .head_ptr     (head_ptr),
    .stop_req     (stop_req),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata),
    .xfer_req     (xfer_req),
    .xfer_addr    (xfer_addr),
    .xfer_len     (xfer_len),
    .xfer_to_host (xfer_to_host),
    .xfer_done    (xfer_done),
    .seg_fin      (seg_fin),
    .seg_len      (seg_len),
    .seg_irq      (seg_irq),
    .walk_end     (walk_end)
  );

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done |-> (!mem_req && !xfer_req));
  // R9
  stop_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_fin && stop_req) |=> chan_done);
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R1
  launch_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (mem_req && !chan_done && mem_addr == $past(head_ptr)));

endmodule

// File: tb/sgdma_walker_tb.sv
`timescale 1ns/1ps
module sgdma_walker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = 6'h24;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_ack = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        xfer_req, xfer_to_host, xfer_done = 1'b0;
  logic [63:0] xfer_addr;
  logic [31:0] xfer_len;
  logic        irq;

  always #2 clk = ~clk;

  sgdma_walker u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_to_host(xfer_to_host), .xfer_done(xfer_done), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];

  // reference model state
  bit          m_done = 1, m_sts = 0, m_abort = 0, m_run = 0;
  logic [31:0] m_bytes = 0, ptr_lo = 0, ptr_hi = 0;
  logic [63:0] m_ptr = 0;
  int          m_word = 0, n_xfer = 0, xwait = 0;
  bit          seen = 0, xd_prev = 0, exp_irq = 0;
  logic [31:0] c_alo, c_ahi, c_len, c_nlo, c_nhi;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(input int boff, input logic [31:0] alo, input logic [31:0] ahi,
                          input logic [31:0] len, input logic [31:0] nlo, input logic [31:0] nhi);
    int b;
    b = boff / 4;
    mem[b+0] = alo; mem[b+1] = ahi; mem[b+2] = 32'hDEAD0000; mem[b+3] = 32'hBEEF0000;
    mem[b+4] = len; mem[b+5] = 32'h5A5A5A5A; mem[b+6] = nlo; mem[b+7] = nhi;
  endtask

  // cycle-by-cycle model, compared at every falling edge
  always @(negedge clk) begin
    if (rst_n && m_run) begin
      exp_irq = 0;
      if (xd_prev) begin
        m_bytes = m_bytes + c_len;
        n_xfer++;
        exp_irq = c_nlo[2];
        if (c_nlo[2]) m_sts = 1;
        if (c_nlo[1] || m_abort) begin m_done = 1; m_abort = 0; end
        else m_ptr = {c_nhi, c_nlo & 32'hFFFFFFE0};
        seen = 0;
        m_word = 0;
      end
      xd_prev = 0;
      xfer_done = 0;
      chk(irq == exp_irq, "R7 irq pulse", 64'(irq), 64'(exp_irq));
      if (reg_addr == 6'h24 && !reg_we) chk(reg_rdata == m_bytes, "R6 byte total", 64'(reg_rdata), 64'(m_bytes));
      if (m_done) chk(!mem_req && !xfer_req, "R5 idle after end", {62'd0, mem_req, xfer_req}, 64'd0);
      if (seen && !xfer_req) chk(0, "R3 request dropped early", 64'(xfer_req), 64'd1);
      mem_ack = 0;
      if (mem_req) begin
        chk(mem_addr == m_ptr + 64'(4*m_word), "R2 R4 fetch address", mem_addr, m_ptr + 64'(4*m_word));
        chk(m_word < 8, "R2 word count", 64'(m_word), 64'd7);
        mem_rdata = mem[mem_addr[9:2]];
        mem_ack = 1;
        m_word++;
      end
      if (xfer_req) begin
        if (!seen) begin
          c_alo = mem[m_ptr[9:2]];
          c_ahi = mem[m_ptr[9:2] + 8'd1];
          c_len = mem[m_ptr[9:2] + 8'd4];
          c_nlo = mem[m_ptr[9:2] + 8'd6];
          c_nhi = mem[m_ptr[9:2] + 8'd7];
          chk(xfer_addr == {c_ahi, c_alo}, "R3 transfer address", xfer_addr, {c_ahi, c_alo});
          chk(xfer_len == c_len, "R3 transfer length", 64'(xfer_len), 64'(c_len));
          chk(xfer_to_host == c_nlo[3], "R3 direction", 64'(xfer_to_host), 64'(c_nlo[3]));
          seen = 1;
          xwait = (c_len >> 2) % 3;
        end
        if (xwait == 0) begin xfer_done = 1; xd_prev = 1; end
        else xwait--;
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #0.5;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 6'h20) begin
      if (d[0] && d[1] && d[8] && m_done) begin
        m_done = 0; m_bytes = 0; m_ptr = {ptr_hi, ptr_lo & 32'hFFFFFFE0}; m_word = 0;
      end
      if (d[2] && !m_done) m_abort = 1;
      if (d[5]) m_sts = 0;
    end
    if (a == 6'h10) ptr_lo = d;
    if (a == 6'h14) ptr_hi = d;
    #0.5;
    reg_we = 0; reg_addr = 6'h24;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(posedge clk); #0.5;
    reg_addr = a;
    #0.5;
    d = reg_rdata;
    reg_addr = 6'h24;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !m_done; i++) @(posedge clk);
  endtask

  task automatic wait_xfers(input int n);
    for (int i = 0; i < 5000 && n_xfer < n; i++) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int na;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // list A: 0x100 -> 0x120 -> 0x1A0 (end), upper pointer word 1
    put_desc(32'h100, 32'h2000_0000, 32'h0000_0003, 32'd16, 32'h0000_0120 | 32'h8, 32'h1);
    put_desc(32'h120, 32'h2000_1000, 32'h0000_0000, 32'd40, 32'h0000_01A0 | 32'h4, 32'h1);
    put_desc(32'h1A0, 32'h2000_2004, 32'h0000_0007, 32'd8,  32'h0000_0000 | 32'hE, 32'h0);
    // list B: 0x200 <-> 0x220 loop; junk bit 4 in a link must be masked
    put_desc(32'h200, 32'h3000_0000, 32'h0000_0001, 32'd12, 32'h0000_0220 | 32'h14, 32'h1);
    put_desc(32'h220, 32'h3000_0100, 32'h0000_0001, 32'd20, 32'h0000_0200 | 32'h8, 32'h1);

    repeat (4) @(posedge clk);
    #0.5 rst_n = 1;
    m_run = 1;

    // R11 reset state
    rd(6'h20, v); chk(v == 32'h10, "R11 csr after reset", 64'(v), 64'h10);
    rd(6'h24, v); chk(v == 0, "R11 total after reset", 64'(v), 64'h0);
    chk(!mem_req && !xfer_req && !irq, "R11 outputs idle", {61'd0, mem_req, xfer_req, irq}, 64'd0);

    // R12 pointer readback, unmasked
    wr(6'h10, 32'h0000_010B);
    wr(6'h14, 32'h0000_0001);
    rd(6'h10, v); chk(v == 32'h10B, "R12 pointer low", 64'(v), 64'h10B);
    rd(6'h14, v); chk(v == 32'h1, "R12 pointer high", 64'(v), 64'h1);

    // R1 start without list-mode bit does nothing
    wr(6'h20, 32'h0000_0003);
    repeat (10) @(posedge clk);
    rd(6'h20, v); chk(v == 32'h10, "R1 incomplete start ignored", 64'(v), 64'h10);

    // R1 R2 R3 R4 R5 R6 R7 list A
    wr(6'h20, 32'h0000_0103);
    rd(6'h20, v); chk(v[4] == 1'b0, "R1 done cleared on start", 64'(v), 64'h0);
    wait_done();
    rd(6'h20, v); chk(v == 32'h30, "R5 R7 done and sticky irq", 64'(v), 64'h30);
    rd(6'h24, v); chk(v == 32'd64, "R6 total list A", 64'(v), 64'd64);
    chk(n_xfer == 3, "R5 transfers in list A", 64'(n_xfer), 64'd3);

    // R8 write-one-to-clear
    wr(6'h20, 32'h0000_0020);
    rd(6'h20, v); chk(v == 32'h10, "R8 sticky bit cleared", 64'(v), 64'h10);

    // R10 abort while done has no effect
    wr(6'h20, 32'h0000_0004);
    repeat (5) @(posedge clk);
    rd(6'h20, v); chk(v == 32'h10, "R10 abort when done", 64'(v), 64'h10);
    rd(6'h24, v); chk(v == 32'd64, "R10 total kept", 64'(v), 64'd64);

    // R4 looping list B, R10 start while busy, R9 abort
    wr(6'h10, 32'h0000_0200);
    wr(6'h20, 32'h0000_0103);
    wait_xfers(6);
    wr(6'h10, 32'h0000_0100);
    wr(6'h20, 32'h0000_0103);
    wait_xfers(11);
    chk(n_xfer >= 11, "R4 loop keeps running", 64'(n_xfer), 64'd11);
    wr(6'h20, 32'h0000_0004);
    na = n_xfer;
    wait_done();
    chk(n_xfer - na <= 1, "R9 stop at boundary", 64'(n_xfer - na), 64'd1);
    rd(6'h20, v); chk(v == 32'h30, "R9 done after abort", 64'(v), 64'h30);
    repeat (20) @(posedge clk);
    rd(6'h24, v); chk(v == m_bytes, "R9 total after abort", 64'(v), 64'(m_bytes));

    // R1 restart from list A clears the total
    wr(6'h20, 32'h0000_0020);
    wr(6'h20, 32'h0000_0103);
    wait_done();
    rd(6'h24, v); chk(v == 32'd64, "R1 total after restart", 64'(v), 64'd64);
    repeat (5) @(posedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule